// File: doc/BRIEF.md
# Three-Address Load/Store Processor Core

This block is a small single-issue processor that runs one instruction per clock cycle, strictly in program order. Its program counter indexes a local instruction store. Each instruction is decoded in that same cycle. The fetch logic, the eight-entry register file and the add/multiply unit are shared by every instruction. Operands come from and go back to a word-addressed data memory outside the block. A combinational load port reads that memory, and a store port writes it on the clock edge that ends the step.

The program is written into the instruction store through a write port, usually while reset is held. When reset is released, execution starts at address 0. It continues until a halt instruction freezes the program counter and raises `done`. The core supports these operations:

- a load from memory into a register,
- a load of a 10-bit immediate into a register,
- a register add,
- a register multiply,
- a store of a register to memory.

A typical program loads two operands, scales one by a constant, accumulates the result and writes it back.

Top module: `tri_addr_core`

## Requirements
- R1: While reset is low and in the first cycle after it, `done` is 0 and `st_en` is 0 during reset; all eight registers hold 0 after reset and the program counter starts at 0.
- R2: Opcode 0 (load memory) drives `ld_addr` with instruction bits [9:0] and writes `ld_data` into the register named by bits [12:10].
- R3: Opcode 1 (load immediate) writes instruction bits [9:0], zero-extended to 32 bits, into the register named by bits [12:10].
- R4: Opcode 3 (add) writes reg[bits 9:7] + reg[bits 6:4], modulo 2^32, into reg[bits 12:10].
- R5: Opcode 2 (multiply) writes the low 32 bits of reg[bits 9:7] × reg[bits 6:4] into reg[bits 12:10].
- R6: Opcode 4 (store) raises `st_en` for that one cycle, with `st_addr` = bits [9:0] and `st_data` = reg[bits 12:10]. No other opcode raises `st_en`.
- R7: Exactly one instruction completes per clock, at consecutive addresses. A register written in one step is seen with its new value by the next instruction.
- R8: Opcode 7 (halt) raises `done` from the edge that ends its step. After that the program counter stays put, no store is issued and `done` stays high until reset.
- R9: Opcodes 5 and 6 change no register and issue no store.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| im_we | input | 1 | Instruction store write strobe |
| im_waddr | input | 6 | Instruction store write address |
| im_wdata | input | 16 | Instruction word to write |
| ld_addr | output | 10 | Data memory load address |
| ld_data | input | 32 | Data memory word at `ld_addr` (combinational) |
| st_en | output | 1 | Store strobe |
| st_addr | output | 10 | Store address |
| st_data | output | 32 | Store data |
| done | output | 1 | Halted |

## Verification
The assertions assume that the instruction store is not rewritten while a program runs. They also assume that `ld_data` is the memory word at the current `ld_addr` within the same cycle. The stimulus therefore writes every program only while reset is held. The bench memory answers loads combinationally and commits stores on the clock edge, as the core expects. Every program ends in a halt, so the frozen-state checks always see a completed run.

// File: rtl/tri_addr_core.sv
module tri_addr_core #(
  parameter int DW  = 32,
  parameter int IAW = 6
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           im_we,
  input  logic [IAW-1:0] im_waddr,
  input  logic [15:0]    im_wdata,
  output logic [9:0]     ld_addr,
  input  logic [DW-1:0]  ld_data,
  output logic           st_en,
  output logic [9:0]     st_addr,
  output logic [DW-1:0]  st_data,
  output logic           done
);
  localparam int NREG  = 8;
  localparam int IDEP  = 1 << IAW;
  localparam logic [2:0] OP_LDM = 3'd0, OP_LDI = 3'd1, OP_MUL = 3'd2,
                         OP_ADD = 3'd3, OP_STM = 3'd4, OP_HLT = 3'd7;

  logic [15:0] imem [IDEP];
  logic [NREG-1:0][DW-1:0] rf;
  logic [IAW-1:0] pc;
  logic           halted;

  logic [15:0]   instr;
  logic [2:0]    op, rc, ra, rb, port_a;
  logic [9:0]    fld;
  logic [DW-1:0] opa, opb, wdata;
  logic          wen, step;

  always_ff @(posedge clk)
    if (im_we) imem[im_waddr] <= im_wdata;

  assign instr  = imem[pc];
  assign op     = instr[15:13];
  assign rc     = instr[12:10];
  assign ra     = instr[9:7];
  assign rb     = instr[6:4];
  assign fld    = instr[9:0];
  assign step   = rst_n && !halted;

  assign port_a = (op == OP_STM) ? rc : ra;
  assign opa    = rf[port_a];
  assign opb    = rf[rb];

  assign wen = step && (op == OP_LDM || op == OP_LDI || op == OP_ADD || op == OP_MUL);

  always_comb begin
    unique case (op)
      OP_LDM:  wdata = ld_data;
      OP_LDI:  wdata = {{(DW-10){1'b0}}, fld};
      OP_ADD:  wdata = opa + opb;
      OP_MUL:  wdata = opa * opb;
      default: wdata = '0;
    endcase
  end

  assign ld_addr = fld;
  assign st_en   = step && (op == OP_STM);
  assign st_addr = fld;
  assign st_data = opa;
  assign done    = halted;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc     <= '0;
      halted <= 1'b0;
      rf     <= '0;
    end else if (!halted) begin
      if (op == OP_HLT) halted <= 1'b1;
      else              pc     <= pc + 1'b1;
      if (wen) rf[rc] <= wdata;
    end
  end

  assert_halt_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> done && $stable(pc));
  assert_no_store_halted_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !st_en);
  assert_pc_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!done && op != OP_HLT) |=> pc == $past(pc) + 1'b1);
  assert_write_lands_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wen |=> rf[$past(rc)] == $past(wdata));
  assert_rf_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !wen |=> $stable(rf));
  assert_store_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
    st_en |=> !$stable(pc) || done);
endmodule

// File: tb/tri_addr_core_tb.sv
module tri_addr_core_tb;
  logic        clk = 0, rst_n = 0, im_we = 0;
  logic [5:0]  im_waddr = '0;
  logic [15:0] im_wdata = '0;
  logic [9:0]  ld_addr, st_addr;
  logic [31:0] ld_data, st_data;
  logic        st_en, done;
  logic [31:0] dmem [1024];
  logic [41:0] expq [$];
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  tri_addr_core u_dut (.clk, .rst_n, .im_we, .im_waddr, .im_wdata,
    .ld_addr, .ld_data, .st_en, .st_addr, .st_data, .done);

  assign ld_data = dmem[ld_addr];
  always @(posedge clk) if (st_en) dmem[st_addr] <= st_data;

  task automatic chk(input string req, input logic [41:0] act, input logic [41:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n && st_en) begin
    if (expq.size() == 0) chk("R6/R8 unexpected store", {st_addr, st_data}, 42'h0);
    else chk("R6 store", {st_addr, st_data}, expq.pop_front());
  end

  function automatic logic [15:0] enc(input int op, input int c, input int a, input int b);
    return {op[2:0], c[2:0], a[2:0], b[2:0], 4'd0};
  endfunction
  function automatic logic [15:0] enci(input int op, input int c, input int f);
    return {op[2:0], c[2:0], f[9:0]};
  endfunction

  task automatic expect_store(input int addr, input logic [31:0] d);
    expq.push_back({addr[9:0], d});
  endtask

  task automatic run(input logic [15:0] prog [], input int exp_cycles, input string tag);
    int n = 0;
    @(negedge clk); rst_n = 0;
    foreach (prog[i]) begin
      im_we = 1; im_waddr = i[5:0]; im_wdata = prog[i];
      @(negedge clk);
    end
    im_we = 0;
    chk("R1 done low in reset", {41'd0, done}, 42'd0);
    chk("R1 no store in reset", {41'd0, st_en}, 42'd0);
    rst_n = 1;
    while (n < 1000) begin
      @(posedge clk); n++;
      @(negedge clk);
      if (done) break;
    end
    chk({"R7 cycles to halt ", tag}, 42'(n), 42'(exp_cycles));
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      chk("R8 done held", {41'd0, done}, 42'd1);
    end
    chk("R6 all stores seen", 42'(expq.size()), 42'd0);
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) dmem[i] = '0;
    fork
      begin
        repeat (5000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog expired");
        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
      end
    join_none

    dmem[100] = 32'd5; dmem[101] = 32'd7;
    expect_store(100, 32'd299);
    run('{enci(0,0,100), enci(0,1,101), enci(1,2,42), enc(2,2,1,2),
          enc(3,0,2,0), enci(4,0,100), enc(7,0,0,0)}, 7, "p1");
    chk("R2/R4/R5 memory word 100", {10'd0, dmem[100]}, 42'd299);

    dmem[300] = 32'hFFFF_FFFF;
    expect_store(200, 32'd0);
    expect_store(201, 32'd1);
    expect_store(202, 32'h3FE);
    expect_store(203, 32'h3FE);
    run('{enci(4,5,200), enci(0,1,300), enc(2,2,1,1), enci(4,2,201),
          enci(1,3,1023), enc(3,4,1,3), enci(4,4,202), enc(5,4,1,1),
          enc(6,4,1,1), enci(4,4,203), enc(7,0,0,0), enci(4,4,204)}, 11, "p2");
    chk("R1/R8 word 204 untouched", {10'd0, dmem[204]}, 42'd0);
    chk("R9 word 203 after no-ops", {10'd0, dmem[203]}, 42'h3FE);

    expect_store(5, 32'd1023);
    expect_store(6, 32'd2046);
    run('{enci(1,7,1023), enci(4,7,5), enc(3,7,7,7), enci(4,7,6), enc(7,0,0,0)}, 5, "p3");
    chk("R3 immediate zero extended", {10'd0, dmem[5]}, 42'd1023);

    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule